// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Generator

This block holds off a link partner on a half-duplex port whose receive buffer is congested. It does this by driving its own transmit path with a jam pattern. A mode input selects between two methods. The carrier method keeps the medium busy so that the partner defers. The collision method jams only when the partner starts a frame, so that the partner sees a collision and backs off.

The carrier method sends fixed-length bursts separated by a gap, and the gap can be set to 64 or 96 bit times. The collision method sends one short jam when it detects the partner's carrier on an arriving frame. That jam ends early if the line goes idle. After the jam, the block waits for the line to go idle, then waits out the gap before it can arm again. All timing is counted in bit times through a per-bit enable, so the same logic serves 10 and 100 Mbit/s. The MAC merges the two outputs into its transmit path. Buffer accounting and backoff are handled elsewhere.

Top module: `bp_jam_gen`

## Requirements
- R1: While reset is asserted and after it is released with no congestion, `tx_en_o` and `jam_bit_o` are 0.
- R2: With `mode_coll_i`=0 (carrier method), half duplex and congestion asserted, a jam burst starts at the next clock edge. Each burst lasts exactly BURST_BITS (default 128) bit times, and no receive carrier or frame is needed.
- R3: Between carrier bursts, `tx_en_o` stays low for exactly 64 bit times when `gap_long_i`=0 and exactly 96 bit times when `gap_long_i`=1. The next burst follows directly if congestion is still present.
- R4: If congestion clears during a burst, that burst completes to its full length and no new burst starts while congestion stays clear.
- R5: With `mode_coll_i`=1 (collision method), a jam starts only when congestion, `crs_i` and `rx_frame_i` are all high. The jam lasts COLL_BITS (default 32) bit times. No further jam starts until `crs_i` has gone low and the gap has elapsed.
- R6: In the collision method, a jam in progress ends at the next clock edge after `crs_i` goes low.
- R7: When `half_duplex_i` is 0, `tx_en_o` is 0 in the same cycle, and any jam in progress is abandoned.
- R8: Jam and gap lengths are counted in `bit_en_i` pulses and not in clock cycles. With one pulse every 4 clocks, a 64 bit-time gap lasts exactly 256 clocks.
- R9: `jam_bit_o` is 1 in the first bit time of each jam and alternates every bit time after that. It is 0 whenever `tx_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle pulse per bit time |
| half_duplex_i | input | 1 | Port runs half duplex |
| congested_i | input | 1 | Receive buffer congestion flag |
| crs_i | input | 1 | Receive carrier sense |
| rx_frame_i | input | 1 | A frame is arriving on the port |
| mode_coll_i | input | 1 | 0 carrier method, 1 collision method |
| gap_long_i | input | 1 | 0 selects 64, 1 selects 96 bit-time gap |
| tx_en_o | output | 1 | Transmit enable for the jam |
| jam_bit_o | output | 1 | Jam data bit |

## Verification
The carrier method is driven with steady congestion under both gap settings, with the gap setting changed in the middle of a burst, and with congestion withdrawn in the middle of a burst. Together these separate burst length, gap length and burst completion. The bit enable is run both every cycle and every fourth cycle, which shows whether lengths are counted in bit times or in clocks. The collision method is given carrier without a frame, a frame with steady carrier, and a carrier that drops mid-jam. These patterns tell arming apart from the early stop and from the wait for idle. Full duplex is applied both before a jam and in the middle of one, and the jam bit pattern is compared every bit time.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_JAM  = 2'd1,
    ST_HOLD = 2'd2,
    ST_GAP  = 2'd3
  } bp_state_e;
endpackage

// File: rtl/bp_bit_timer.sv
module bp_bit_timer #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/bp_jam_fsm.sv
module bp_jam_fsm
  import bp_jam_pkg::*;
#(
  parameter int BURST_BITS = 128,
  parameter int COLL_BITS  = 32,
  parameter int GAP_SHORT  = 64,
  parameter int GAP_LONG   = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic half_duplex_i,
  input  logic congested_i,
  input  logic crs_i,
  input  logic rx_frame_i,
  input  logic mode_coll_i,
  input  logic gap_long_i,
  output logic jam_active_o,
  output logic jam_start_o
);
  localparam int MAX_AB = (BURST_BITS > COLL_BITS) ? BURST_BITS : COLL_BITS;
  localparam int MAX_GP = (GAP_SHORT > GAP_LONG) ? GAP_SHORT : GAP_LONG;
  localparam int MAX_ALL = (MAX_AB > MAX_GP) ? MAX_AB : MAX_GP;
  localparam int CW = $clog2(MAX_ALL);

  bp_state_e   state_q, state_d;
  logic        coll_q, coll_d;
  logic        load;
  logic [CW-1:0] load_val, gap_val;
  logic        last, phase_end, carrier_go, coll_go;

  assign carrier_go = half_duplex_i && congested_i && !mode_coll_i;
  assign coll_go    = half_duplex_i && congested_i && mode_coll_i && crs_i && rx_frame_i;
  assign gap_val    = gap_long_i ? CW'(GAP_LONG - 1) : CW'(GAP_SHORT - 1);
  assign phase_end  = bit_en_i && last;

  always_comb begin
    state_d  = state_q;
    coll_d   = coll_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (carrier_go) begin
          state_d = ST_JAM; load = 1'b1; load_val = CW'(BURST_BITS - 1); coll_d = 1'b0;
        end else if (coll_go) begin
          state_d = ST_JAM; load = 1'b1; load_val = CW'(COLL_BITS - 1); coll_d = 1'b1;
        end
      end
      ST_JAM: begin
        if (coll_q && !crs_i) begin
          state_d = ST_GAP; load = 1'b1; load_val = gap_val;
        end else if (phase_end) begin
          if (coll_q) state_d = ST_HOLD;
          else begin
            state_d = ST_GAP; load = 1'b1; load_val = gap_val;
          end
        end
      end
      ST_HOLD: begin
        if (!crs_i) begin
          state_d = ST_GAP; load = 1'b1; load_val = gap_val;
        end
      end
      ST_GAP: begin
        if (phase_end) begin
          if (carrier_go) begin
            state_d = ST_JAM; load = 1'b1; load_val = CW'(BURST_BITS - 1); coll_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!half_duplex_i) begin
      state_d = ST_IDLE;
      load    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      coll_q  <= coll_d;
    end
  end

  bp_bit_timer #(.W(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (bit_en_i),
    .last_o    (last)
  );

  assign jam_active_o = (state_q == ST_JAM);
  assign jam_start_o  = load && (state_d == ST_JAM);
endmodule

// File: rtl/bp_jam_pattern.sv
module bp_jam_pattern (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic bit_en_i,
  output logic bit_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ph_q <= 1'b1;
    else if (start_i)              ph_q <= 1'b1;
    else if (active_i && bit_en_i) ph_q <= ~ph_q;
  end

  assign bit_o = active_i && ph_q;
endmodule

// File: rtl/bp_jam_gen.sv
module bp_jam_gen #(
  parameter int BURST_BITS = 128,
  parameter int COLL_BITS  = 32,
  parameter int GAP_SHORT  = 64,
  parameter int GAP_LONG   = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic half_duplex_i,
  input  logic congested_i,
  input  logic crs_i,
  input  logic rx_frame_i,
  input  logic mode_coll_i,
  input  logic gap_long_i,
  output logic tx_en_o,
  output logic jam_bit_o
);
  logic jam_active, jam_start, pat_bit;

  bp_jam_fsm #(
    .BURST_BITS(BURST_BITS),
    .COLL_BITS (COLL_BITS),
    .GAP_SHORT (GAP_SHORT),
    .GAP_LONG  (GAP_LONG)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .half_duplex_i(half_duplex_i),
    .congested_i  (congested_i),
    .crs_i        (crs_i),
    .rx_frame_i   (rx_frame_i),
    .mode_coll_i  (mode_coll_i),
    .gap_long_i   (gap_long_i),
    .jam_active_o (jam_active),
    .jam_start_o  (jam_start)
  );

  bp_jam_pattern u_pat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (jam_start),
    .active_i(jam_active),
    .bit_en_i(bit_en_i),
    .bit_o   (pat_bit)
  );

  // full duplex masks the jam at once
  assign tx_en_o   = jam_active && half_duplex_i;
  assign jam_bit_o = pat_bit && half_duplex_i;
endmodule

// File: rtl/bp_jam_gen_chk.sv
module bp_jam_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic half_duplex_i,
  input logic congested_i,
  input logic crs_i,
  input logic rx_frame_i,
  input logic mode_coll_i,
  input logic gap_long_i,
  input logic tx_en_o,
  input logic jam_bit_o
);
  AST_FD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_duplex_i |-> !tx_en_o); // R7

  AST_DATA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> !jam_bit_o); // R9

  AST_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o && $past(tx_en_o) && $past(bit_en_i) |-> jam_bit_o != $past(jam_bit_o)); // R9

  AST_START_CONGESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(congested_i) && $past(half_duplex_i)); // R4

  AST_COLL_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) && $past(mode_coll_i) |-> $past(crs_i) && $past(rx_frame_i)); // R5

  AST_END_ON_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> $past(bit_en_i) || !$past(crs_i) || !$past(half_duplex_i) || !half_duplex_i); // R8

  logic unused_gap;
  assign unused_gap = gap_long_i;
endmodule

bind bp_jam_gen bp_jam_gen_chk u_chk (.*);

// File: tb/tb_bp_jam_gen.sv
module tb_bp_jam_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b1;
  logic half_duplex = 1'b0, congested = 1'b0, crs = 1'b0, rx_frame = 1'b0;
  logic mode_coll = 1'b0, gap_long = 1'b0;
  logic tx_en, jam_bit;

  int checks = 0, fails = 0, div = 1, divc = 0, cyc = 0;

  always #10 clk = ~clk;

  bp_jam_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .half_duplex_i(half_duplex),
    .congested_i(congested), .crs_i(crs), .rx_frame_i(rx_frame),
    .mode_coll_i(mode_coll), .gap_long_i(gap_long), .tx_en_o(tx_en), .jam_bit_o(jam_bit)
  );

  always @(negedge clk) begin
    divc = (divc + 1 >= div) ? 0 : divc + 1;
    bit_en = (divc == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_tx(input logic v, output int n);
    n = 0;
    while (tx_en !== v && n < 3000) begin step(); n++; end
  endtask

  // length of the current run of tx_en==v, in cycles and bit pulses; checks pattern
  task automatic run_len(input logic v, output int cycles, output int pulses, output int perr);
    logic exp_b = 1'b1;
    cycles = 0; pulses = 0; perr = 0;
    while (tx_en === v && cycles < 5000) begin
      if (v && jam_bit !== exp_b) perr++;
      if (!v && jam_bit !== 1'b0) perr++;
      if (bit_en) begin pulses++; exp_b = ~exp_b; end
      cycles++;
      step();
    end
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin step(); if (tx_en !== 1'b0) hits++; end
  endtask

  int c, p, e, n, h, first;

  initial begin
    // R1 reset
    repeat (3) step();
    chk(tx_en === 1'b0 && jam_bit === 1'b0, "R1 in reset", tx_en, 0);
    rst_ni = 1'b1;
    quiet(20, h);
    chk(h == 0, "R1 idle after reset", h, 0);

    // R2/R3/R9 carrier method, short gap
    half_duplex = 1'b1; congested = 1'b1;
    step();
    chk(tx_en === 1'b1, "R2 burst starts next edge", tx_en, 1);
    run_len(1'b1, c, p, e);
    chk(p == 128, "R2 burst length", p, 128);
    chk(e == 0, "R9 jam pattern", e, 0);
    run_len(1'b0, c, p, e);
    chk(p == 64, "R3 short gap", p, 64);
    gap_long = 1'b1;
    run_len(1'b1, c, p, e);
    chk(p == 128, "R2 second burst", p, 128);
    chk(e == 0, "R9 pattern second burst", e, 0);
    run_len(1'b0, c, p, e);
    chk(p == 96, "R3 long gap", p, 96);

    // R4 congestion clears mid burst
    for (int i = 0; i < 20; i++) step();
    congested = 1'b0;
    run_len(1'b1, c, p, e);
    chk(p + 20 == 128, "R4 burst completes", p + 20, 128);
    quiet(400, h);
    chk(h == 0, "R4 no new burst", h, 0);

    // R8 bit enable every 4 clocks
    div = 4; gap_long = 1'b0; congested = 1'b1;
    wait_tx(1'b1, n);
    run_len(1'b1, c, p, e);
    chk(p == 128, "R8 burst pulses", p, 128);
    chk(c >= 509 && c <= 512, "R8 burst clocks", c, 512);
    run_len(1'b0, c, p, e);
    chk(c == 256, "R8 gap clocks", c, 256);
    congested = 1'b0;
    run_len(1'b1, c, p, e);
    quiet(600, h);
    div = 1;
    quiet(10, h);

    // R5 collision method arming
    mode_coll = 1'b1; congested = 1'b1;
    quiet(300, h);
    chk(h == 0, "R5 no jam without carrier", h, 0);
    crs = 1'b1;
    quiet(100, h);
    chk(h == 0, "R5 no jam without frame", h, 0);
    rx_frame = 1'b1;
    step();
    chk(tx_en === 1'b1, "R5 jam on frame", tx_en, 1);
    run_len(1'b1, c, p, e);
    chk(p == 32, "R5 jam length", p, 32);
    chk(e == 0, "R9 pattern collision jam", e, 0);
    quiet(200, h);
    chk(h == 0, "R5 hold while carrier", h, 0);
    crs = 1'b0; rx_frame = 1'b0;
    quiet(100, h);
    chk(h == 0, "R5 idle line no jam", h, 0);

    // R6 early stop on idle line
    crs = 1'b1; rx_frame = 1'b1;
    wait_tx(1'b1, n);
    first = 0;
    for (int i = 0; i < 10; i++) begin if (tx_en === 1'b1) first++; step(); end
    crs = 1'b0; rx_frame = 1'b0;
    #1;
    chk(first == 10, "R6 jam before drop", first, 10);
    step();
    chk(tx_en === 1'b0, "R6 stop after idle", tx_en, 0);
    quiet(200, h);
    chk(h == 0, "R6 stays quiet", h, 0);

    // R7 full duplex
    mode_coll = 1'b0; half_duplex = 1'b0;
    quiet(300, h);
    chk(h == 0, "R7 full duplex silent", h, 0);
    half_duplex = 1'b1;
    wait_tx(1'b1, n);
    for (int i = 0; i < 5; i++) step();
    half_duplex = 1'b0;
    #1;
    chk(tx_en === 1'b0 && jam_bit === 1'b0, "R7 masked same cycle", tx_en, 0);
    congested = 1'b0;
    quiet(200, h);
    chk(h == 0, "R7 jam abandoned", h, 0);
    half_duplex = 1'b1;
    quiet(50, h);
    chk(h == 0, "R7 no resume", h, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule